// File: doc/BRIEF.md
# Calendar Real-Time Clock with Deferred Register Commit

This core keeps wall-clock time (seconds, minutes, hours) and a calendar date (day of month, month, year) and advances them from a one-second tick pulse. The year is held as an offset from a base year set by parameter, and a stored leap flag next to it decides the length of February. Software reaches the core through three 32-bit words on a simple register bus: a status word, a date word and a time word. Reads are combinational and can be repeated until two reads of both words agree, which gives a consistent date/time pair.

A write to the time or date word does not take effect at once. The value is held in a staging register and lands after a fixed number of core cycles, which stands in for a slower clock domain. For that span a busy bit per word is set in the status word, and software polls it before it trusts the new value or writes again. The live counters keep running while a commit is pending and are overwritten when it lands.

Top module: `rtc_calendar`

## Requirements
- R1: After synchronous reset the time word reads 0 (00:00:00), the date word reads 0x00000101 (day 1, month 1, year offset 0, leap flag equal to the leap status of the base year) and the status word reads 0.
- R2: The time word at offset 0x8 holds seconds in bits [5:0], minutes in bits [13:8] and hours in bits [20:16], with all other bits read as 0; a written value is what the word reads back once its commit lands.
- R3: The date word at offset 0x4 holds day in bits [4:0], month in bits [11:8], the year offset in YEAR_W bits from bit 16 and the leap flag at bit 16+YEAR_W, with all other bits read as 0.
- R4: On a tick, seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0 and carry into the date.
- R5: An accepted write to the time word sets status bit 8 on the next edge; the bit stays set for exactly COMMIT_CYC cycles and clears on the same edge that loads the staged value.
- R6: An accepted write to the date word sets status bit 7 on the next edge, for exactly COMMIT_CYC cycles, clearing on the edge that loads the staged date.
- R7: While a commit is pending the live counters keep advancing on ticks; the staged value then replaces them, and it wins over a tick that arrives on the commit edge.
- R8: A day carry moves to the next day, or to day 1 of the next month once the month's length is reached (30 days for months 4, 6, 9, 11; 31 otherwise; February 29 days with the leap flag set, else 28), and month 12 wraps to month 1.
- R9: When the year offset advances on its own, the leap flag is recomputed for base year plus offset: divisible by 4, except centuries not divisible by 400.
- R10: A write to the time or date word while its own busy bit is set is ignored; the first staged value is the one that lands.
- R11: The status word has no writable bits; writing it changes neither its value nor the time and date words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr |

## Verification
The calendar is driven with settings placed just before each kind of boundary: a plain second step, a minute carry, midnight into a leap and a common February, a 30-day month end and two New Year rollovers, so that a wrong month table, a stuck leap flag or a wrong leap rule each gives a different date word. The deferred commit is tried alone, with a second write inside the busy window, with ticks landing during the delay, and with a tick on the very edge the commit lands, which separates "staged wins" from "tick wins" and from "write accepted while busy". A behavioural model of every register is compared against the read port on each cycle while the address rotates through the words.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    // Packed time-of-day value carried between the stage and the counter
    typedef struct packed {
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sc;
    } hms_t;

    localparam int HMS_W = $bits(hms_t);

    // Word offsets on the register bus
    localparam int OFS_CTRL = 'h0;
    localparam int OFS_DATE = 'h4;
    localparam int OFS_TIME = 'h8;

    // Field positions inside the words
    localparam int SEC_LSB  = 0;
    localparam int MIN_LSB  = 8;
    localparam int HR_LSB   = 16;
    localparam int DAY_LSB  = 0;
    localparam int MON_LSB  = 8;
    localparam int YEAR_LSB = 16;

    // Busy flags in the status word
    localparam int BUSY_TIME_BIT = 8;
    localparam int BUSY_DATE_BIT = 7;

    function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
        logic [4:0] n;
        case (mon)
            4'd2:                      n = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   n = 5'd30;
            default:                   n = 5'd31;
        endcase
        return n;
    endfunction

    function automatic logic leap_of(input int unsigned yr);
        return ((yr % 4) == 0 && (yr % 100) != 0) || ((yr % 400) == 0);
    endfunction

    function automatic hms_t hms_from_word(input logic [31:0] w);
        hms_t t;
        t.sc = w[SEC_LSB +: 6];
        t.mn = w[MIN_LSB +: 6];
        t.hr = w[HR_LSB  +: 5];
        return t;
    endfunction

    function automatic logic [31:0] hms_to_word(input hms_t t);
        logic [31:0] w;
        w = '0;
        w[SEC_LSB +: 6] = t.sc;
        w[MIN_LSB +: 6] = t.mn;
        w[HR_LSB  +: 5] = t.hr;
        return w;
    endfunction

endpackage

// File: rtl/rtc_commit_stage.sv
// Holds one written value for DLY cycles, then issues a single load pulse.
module rtc_commit_stage #(
    parameter int W   = 17,
    parameter int DLY = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic [W-1:0] din,
    output logic         busy,
    output logic         fire,
    output logic [W-1:0] dout
);
    localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] CNT_START = CW'(DLY - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [W-1:0]  data_q;

    assign fire = busy_q && (cnt_q == '0);
    assign busy = busy_q;
    assign dout = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            data_q <= '0;
        end else if (!busy_q) begin
            if (req) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_START;
                data_q <= din;
            end
        end else if (fire) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/rtc_hms_counter.sv
module rtc_hms_counter
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic load,
    input  hms_t load_val,
    output hms_t q,
    output logic day_carry
);
    hms_t cur_q, nxt;
    logic carry;

    always_comb begin
        nxt   = cur_q;
        carry = 1'b0;
        if (load) begin
            nxt = load_val;
        end else if (tick) begin
            if (cur_q.sc >= 6'd59) begin
                nxt.sc = '0;
                if (cur_q.mn >= 6'd59) begin
                    nxt.mn = '0;
                    if (cur_q.hr >= 5'd23) begin
                        nxt.hr = '0;
                        carry  = 1'b1;
                    end else begin
                        nxt.hr = cur_q.hr + 5'd1;
                    end
                end else begin
                    nxt.mn = cur_q.mn + 6'd1;
                end
            end else begin
                nxt.sc = cur_q.sc + 6'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end

    assign q         = cur_q;
    assign day_carry = carry;

endmodule

// File: rtl/rtc_ymd_counter.sv
module rtc_ymd_counter
    import rtc_cal_pkg::*;
#(
    parameter int          YEAR_W    = 6,
    parameter int unsigned BASE_YEAR = 2010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              load,
    input  logic [4:0]        load_day,
    input  logic [3:0]        load_mon,
    input  logic [YEAR_W-1:0] load_year,
    input  logic              load_leap,
    output logic [4:0]        day,
    output logic [3:0]        mon,
    output logic [YEAR_W-1:0] year,
    output logic              leap
);
    localparam logic RESET_LEAP = leap_of(BASE_YEAR);

    logic [4:0]        day_q,  day_n;
    logic [3:0]        mon_q,  mon_n;
    logic [YEAR_W-1:0] year_q, year_n, year_inc;
    logic              leap_q, leap_n;

    assign year_inc = year_q + 1'b1;

    always_comb begin
        day_n  = day_q;
        mon_n  = mon_q;
        year_n = year_q;
        leap_n = leap_q;
        if (load) begin
            day_n  = load_day;
            mon_n  = load_mon;
            year_n = load_year;
            leap_n = load_leap;
        end else if (inc) begin
            if (day_q >= month_days(mon_q, leap_q)) begin
                day_n = 5'd1;
                if (mon_q >= 4'd12) begin
                    mon_n  = 4'd1;
                    year_n = year_inc;
                    leap_n = leap_of(BASE_YEAR + 32'(year_inc));
                end else begin
                    mon_n = mon_q + 4'd1;
                end
            end else begin
                day_n = day_q + 5'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            day_q  <= 5'd1;
            mon_q  <= 4'd1;
            year_q <= '0;
            leap_q <= RESET_LEAP;
        end else begin
            day_q  <= day_n;
            mon_q  <= mon_n;
            year_q <= year_n;
            leap_q <= leap_n;
        end
    end

    assign day  = day_q;
    assign mon  = mon_q;
    assign year = year_q;
    assign leap = leap_q;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int          YEAR_W     = 6,
    parameter int unsigned BASE_YEAR  = 2010,
    parameter int          COMMIT_CYC = 8,
    parameter int          ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int LEAP_POS = YEAR_LSB + YEAR_W;
    localparam int DSTAGE_W = 1 + YEAR_W + 4 + 5;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(OFS_DATE);
    localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(OFS_TIME);

    // Write decode
    logic wr_time, wr_date;
    assign wr_time = bus_wr && (bus_addr == A_TIME);
    assign wr_date = bus_wr && (bus_addr == A_DATE);

    // Time staging
    logic             t_busy, t_fire;
    logic [HMS_W-1:0] t_stage;
    hms_t             t_in;
    assign t_in = hms_from_word(bus_wdata);

    rtc_commit_stage #(.W(HMS_W), .DLY(COMMIT_CYC)) u_tstage (
        .clk (clk),
        .rst (rst),
        .req (wr_time),
        .din (t_in),
        .busy(t_busy),
        .fire(t_fire),
        .dout(t_stage)
    );

    // Date staging: {leap, year, month, day}
    logic                t_dummy_unused;
    logic                d_busy, d_fire;
    logic [DSTAGE_W-1:0] d_in, d_stage;
    assign d_in = {bus_wdata[LEAP_POS], bus_wdata[YEAR_LSB +: YEAR_W],
                   bus_wdata[MON_LSB +: 4], bus_wdata[DAY_LSB +: 5]};
    assign t_dummy_unused = 1'b0;

    rtc_commit_stage #(.W(DSTAGE_W), .DLY(COMMIT_CYC)) u_dstage (
        .clk (clk),
        .rst (rst),
        .req (wr_date),
        .din (d_in),
        .busy(d_busy),
        .fire(d_fire),
        .dout(d_stage)
    );

    // Time of day
    hms_t time_q;
    logic day_carry;

    rtc_hms_counter u_hms (
        .clk      (clk),
        .rst      (rst),
        .tick     (sec_tick),
        .load     (t_fire),
        .load_val (hms_t'(t_stage)),
        .q        (time_q),
        .day_carry(day_carry)
    );

    // Calendar date
    logic [4:0]        cal_day;
    logic [3:0]        cal_mon;
    logic [YEAR_W-1:0] cal_year;
    logic              cal_leap;

    rtc_ymd_counter #(.YEAR_W(YEAR_W), .BASE_YEAR(BASE_YEAR)) u_ymd (
        .clk      (clk),
        .rst      (rst),
        .inc      (day_carry),
        .load     (d_fire),
        .load_day (d_stage[4:0]),
        .load_mon (d_stage[8:5]),
        .load_year(d_stage[9 +: YEAR_W]),
        .load_leap(d_stage[DSTAGE_W-1]),
        .day      (cal_day),
        .mon      (cal_mon),
        .year     (cal_year),
        .leap     (cal_leap)
    );

    // Read path
    logic [31:0] date_word;
    always_comb begin
        date_word = '0;
        date_word[DAY_LSB  +: 5]      = cal_day;
        date_word[MON_LSB  +: 4]      = cal_mon;
        date_word[YEAR_LSB +: YEAR_W] = cal_year;
        date_word[LEAP_POS]           = cal_leap;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[BUSY_TIME_BIT] = t_busy;
            bus_rdata[BUSY_DATE_BIT] = d_busy;
        end else if (bus_addr == A_DATE) begin
            bus_rdata = date_word;
        end else if (bus_addr == A_TIME) begin
            bus_rdata = hms_to_word(time_q);
        end
    end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
#(
    parameter int          YEAR_W     = 6,
    parameter int unsigned BASE_YEAR  = 2010,
    parameter int          COMMIT_CYC = 8,
    parameter int          ADDR_W     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input hms_t              time_q,
    input logic              t_busy,
    input logic              t_fire,
    input logic [HMS_W-1:0]  t_stage,
    input logic              d_busy,
    input logic [YEAR_W-1:0] cal_year,
    input logic              cal_leap,
    input logic              d_fire
);
    localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(OFS_DATE);
    localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(OFS_TIME);

    // Count busy cycles so that the window length needs no long $past
    logic [31:0] t_run, d_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            t_run <= '0;
            d_run <= '0;
        end else begin
            t_run <= t_busy ? t_run + 1 : '0;
            d_run <= d_busy ? d_run + 1 : '0;
        end
    end

    a_r5_time_busy_set: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == A_TIME && !t_busy |=> t_busy);

    a_r5_time_busy_len: assert property (@(posedge clk) disable iff (rst)
        t_busy |-> t_run < 32'(COMMIT_CYC));

    a_r5_time_busy_end: assert property (@(posedge clk) disable iff (rst)
        $fell(t_busy) |-> $past(t_run) == 32'(COMMIT_CYC - 1));

    a_r6_date_busy_set: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == A_DATE && !d_busy |=> d_busy);

    a_r6_date_busy_end: assert property (@(posedge clk) disable iff (rst)
        $fell(d_busy) |-> $past(d_run) == 32'(COMMIT_CYC - 1));

    a_r7_commit_wins: assert property (@(posedge clk) disable iff (rst)
        t_fire |=> time_q == hms_t'($past(t_stage)));

    a_r10_time_ignore: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == A_TIME && t_busy |=> $stable(t_stage));

    a_r4_sec_step: assert property (@(posedge clk) disable iff (rst)
        sec_tick && !t_fire && time_q.sc < 6'd59 |=> time_q.sc == 6'($past(time_q.sc) + 6'd1));

    a_r9_leap_recalc: assert property (@(posedge clk) disable iff (rst)
        cal_year != $past(cal_year) && !$past(d_fire) |->
            cal_leap == leap_of(BASE_YEAR + 32'(cal_year)));

endmodule

bind rtc_calendar rtc_calendar_chk #(
    .YEAR_W(YEAR_W), .BASE_YEAR(BASE_YEAR), .COMMIT_CYC(COMMIT_CYC), .ADDR_W(ADDR_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .sec_tick(sec_tick),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .time_q  (time_q),
    .t_busy  (t_busy),
    .t_fire  (t_fire),
    .t_stage (t_stage),
    .d_busy  (d_busy),
    .cal_year(cal_year),
    .cal_leap(cal_leap),
    .d_fire  (d_fire)
);

// File: tb/rtc_calendar_tb_top.sv
module rtc_calendar_tb_top;
    localparam int YW   = 6;
    localparam int BASE = 2010;
    localparam int DLY  = 8;
    localparam int AW   = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sec_tick = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #4 clk = ~clk;

    rtc_calendar #(.YEAR_W(YW), .BASE_YEAR(BASE), .COMMIT_CYC(DLY), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // ---------------- behavioural reference model ----------------
    int m_s, m_mi, m_h, m_d, m_mo, m_y, m_lp;
    int t_b, t_c, ts_s, ts_mi, ts_h;
    int d_b, d_c, ds_d, ds_mo, ds_y, ds_lp;

    function automatic int is_leap(int yr);
        return (((yr % 4) == 0 && (yr % 100) != 0) || (yr % 400) == 0) ? 1 : 0;
    endfunction

    function automatic int mlen(int mo, int lp);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] exp_reg(int a);
        case (a)
            0: return 32'((t_b << 8) | (d_b << 7));
            4: return 32'(m_d | (m_mo << 8) | (m_y << 16) | (m_lp << (16 + YW)));
            8: return 32'(m_s | (m_mi << 8) | (m_h << 16));
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            0: return "R5/R6 status";
            4: return "R3 date";
            8: return "R2 time";
            default: return "R11 unmapped";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 0; m_lp = is_leap(BASE);
            t_b = 0; t_c = 0; ts_s = 0; ts_mi = 0; ts_h = 0;
            d_b = 0; d_c = 0; ds_d = 0; ds_mo = 0; ds_y = 0; ds_lp = 0;
        end else begin
            int tf, df, tb_old, db_old, carry;
            tf = (t_b && t_c == 0) ? 1 : 0;
            df = (d_b && d_c == 0) ? 1 : 0;
            tb_old = t_b;
            db_old = d_b;
            carry = 0;
            if (sec_tick && !tf) begin
                if (m_s >= 59) begin
                    m_s = 0;
                    if (m_mi >= 59) begin
                        m_mi = 0;
                        if (m_h >= 23) begin m_h = 0; carry = 1; end
                        else m_h++;
                    end else m_mi++;
                end else m_s++;
            end
            if (carry && !df) begin
                if (m_d >= mlen(m_mo, m_lp)) begin
                    m_d = 1;
                    if (m_mo >= 12) begin
                        m_mo = 1;
                        m_y = (m_y + 1) % (1 << YW);
                        m_lp = is_leap(BASE + m_y);
                    end else m_mo++;
                end else m_d++;
            end
            if (tf) begin m_s = ts_s; m_mi = ts_mi; m_h = ts_h; t_b = 0; end
            else if (t_b) t_c--;
            if (df) begin m_d = ds_d; m_mo = ds_mo; m_y = ds_y; m_lp = ds_lp; d_b = 0; end
            else if (d_b) d_c--;
            if (bus_wr && bus_addr == 8 && !tb_old) begin
                t_b = 1; t_c = DLY - 1;
                ts_s = int'(bus_wdata[5:0]); ts_mi = int'(bus_wdata[13:8]); ts_h = int'(bus_wdata[20:16]);
            end
            if (bus_wr && bus_addr == 4 && !db_old) begin
                d_b = 1; d_c = DLY - 1;
                ds_d = int'(bus_wdata[4:0]); ds_mo = int'(bus_wdata[11:8]);
                ds_y = int'(bus_wdata[16 +: YW]); ds_lp = int'(bus_wdata[16 + YW]);
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare the read port against the model on every cycle, mid-period
    always @(negedge clk) begin
        if (!rst && !done) check(tag_of(int'(bus_addr)), bus_rdata, exp_reg(int'(bus_addr)));
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic bus_write(int a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_addr = AW'(a + 4);
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        step();
        sec_tick = 1'b0;
    endtask

    task automatic read_expect(int a, logic [31:0] exp, string tag);
        bus_addr = AW'(a);
        @(negedge clk);
        check(tag, bus_rdata, exp);
        step();
    endtask

    task automatic set_both(logic [31:0] date_w, logic [31:0] time_w);
        bus_write(4, date_w);
        bus_write(8, time_w);
        wait_n(DLY + 2);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): got hang expected finish");
            finish_run();
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;

        // R1 reset values
        read_expect(0, 32'h0000_0000, "R1 status after reset");
        read_expect(4, 32'h0000_0101, "R1 date after reset");
        read_expect(8, 32'h0000_0000, "R1 time after reset");

        // R5 / R2 time commit
        bus_write(8, 32'h0017_3B3A);
        read_expect(0, 32'h0000_0100, "R5 time busy set");
        wait_n(DLY + 1);
        read_expect(0, 32'h0000_0000, "R5 time busy cleared");
        read_expect(8, 32'h0017_3B3A, "R2 time committed");

        // R6 / R3 date commit: 2012-02-28, leap
        bus_write(4, 32'h0042_021C);
        read_expect(0, 32'h0000_0080, "R6 date busy set");
        wait_n(DLY + 1);
        read_expect(4, 32'h0042_021C, "R3 date committed");

        // R4 / R8 rollover into leap day
        tick();
        read_expect(8, 32'h0017_3B3B, "R4 second step");
        tick();
        read_expect(8, 32'h0000_0000, "R4 midnight wrap");
        read_expect(4, 32'h0042_021D, "R8 leap February 29");

        // R4 minute carry
        bus_write(8, 32'h0000_003B);
        wait_n(DLY + 1);
        tick();
        read_expect(8, 32'h0000_0100, "R4 minute carry");

        // R8 common February
        set_both(32'h0003_021C, 32'h0017_3B3B);
        tick();
        read_expect(4, 32'h0003_0301, "R8 common February to March");

        // R8 thirty-day month
        set_both(32'h0007_041E, 32'h0017_3B3B);
        tick();
        read_expect(4, 32'h0007_0501, "R8 April 30 to May 1");

        // R9 new year with leap recompute
        set_both(32'h0005_0C1F, 32'h0017_3B3B);
        tick();
        read_expect(4, 32'h0046_0101, "R9 year to 2016 leap set");
        set_both(32'h0046_0C1F, 32'h0017_3B3B);
        tick();
        read_expect(4, 32'h0007_0101, "R9 year to 2017 leap clear");

        // R10 second write during busy ignored
        bus_write(8, 32'h0001_0203);
        bus_write(8, 32'h0004_0506);
        wait_n(DLY + 1);
        read_expect(8, 32'h0001_0203, "R10 write while busy ignored");

        // R7 counters run during delay, then staged value lands
        bus_write(8, 32'h0000_0A00);
        tick();
        read_expect(8, 32'h0001_0204, "R7 counter runs while pending");
        read_expect(0, 32'h0000_0100, "R7 still busy");
        wait_n(DLY + 1);
        read_expect(8, 32'h0000_0A00, "R7 staged value replaces");
        tick();
        read_expect(8, 32'h0000_0A01, "R7 counting after commit");

        // R11 status word not writable
        bus_write(0, 32'hFFFF_FFFF);
        read_expect(0, 32'h0000_0000, "R11 status unchanged");
        read_expect(8, 32'h0000_0A01, "R11 time unchanged");

        // R7 tick on the commit edge loses to the staged value
        bus_write(8, 32'h0000_0505);
        wait_n(DLY - 1);
        tick();
        read_expect(8, 32'h0000_0505, "R7 commit beats same-edge tick");

        // Rotate the address with ticks so the model compare covers all words
        for (int i = 0; i < 200; i++) begin
            bus_addr = AW'((i % 3) * 4);
            sec_tick = (i % 2 == 0);
            step();
        end
        sec_tick = 1'b0;
        step();

        finish_run();
    end

endmodule